// File: doc/BRIEF.md
# Binary Logarithm Converter

The block turns a 16-bit unsigned integer into a 16-bit fixed-point approximation of its base-2 logarithm. The upper four result bits hold the integer part, which is the bit index of the most significant set bit of the operand. The lower twelve bits hold a fraction. This fraction is the linear approximation log2(1+f) ≈ f, where f is formed by the operand bits that sit below that leading one. The approximation error is known and the block does not correct it.

The leading-one search is made of 4-bit priority detectors and one detector across the groups, so it resolves in two logic levels. It returns the bit index as a binary number. That number drives a logarithmic shifter with one stage per bit of the shift amount. The shifter left-justifies the bits below the leading one into the fraction field.

An operand is accepted when its strobe is high. The result, a zero flag and a valid flag appear on the registered outputs one clock later. When the strobe is low, the result registers keep their contents.

Top module: `log2_conv`

## Requirements
- R1: One clock after `in_valid` is high with a nonzero `in_data`, `out_log[15:12]` equals floor(log2(`in_data`)), the index of its highest set bit.
- R2: In that same case, `out_log[11:0]` holds the `in_data` bits below the leading one, most significant first, starting at bit 11. Any of those bits beyond the twelfth are dropped. A power of two gives a fraction of zero, and 0xFFFF gives 0xFFFF.
- R3: When fewer than twelve bits lie below the leading one, the unused low positions of the fraction are zero. For example, 0x0005 gives 0x2400.
- R4: One clock after `in_valid` is high with `in_data` equal to zero, `out_log` is 0x0000 and `out_zero` is 1. `out_zero` is 0 after any nonzero operand.
- R5: `out_valid` equals the value `in_valid` had one clock earlier.
- R6: While `in_valid` is low, `out_log` and `out_zero` hold their previous values, whatever `in_data` carries.
- R7: While `rst_n` is low, `out_log`, `out_zero` and `out_valid` are all 0, and they go to 0 as soon as `rst_n` falls. After `rst_n` rises, the block accepts operands from the third rising clock edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; its release is synchronised inside the block |
| in_valid | input | 1 | Operand strobe; also the capture enable for the result registers |
| in_data | input | 16 | Unsigned operand |
| out_valid | output | 1 | High one clock after an accepted operand |
| out_log | output | 16 | Result: integer part in [15:12], fraction in [11:0] |
| out_zero | output | 1 | High when the last accepted operand was zero |

## Verification
A wrong group choice in the leading-one search shows up one clock after the operand. The integer part is then off by a multiple of four, and the fraction is shifted by the same amount. A wrong bit choice inside a group gives an integer part that is off by one to three. A stuck or swapped stage in the shifter leaves the integer part correct but gives a fraction that is shifted by a power of two. This shows only for operands whose shift amount uses that stage, so every operand value is applied. A broken capture enable shows at the first cycle with the strobe low, because the held result then changes.

// File: rtl/log2_pkg.sv
package log2_pkg;
  // Default geometry of the converter
  localparam int unsigned LG_DATA_W = 16;  // operand width
  localparam int unsigned LG_FRAC_W = 12;  // fraction bits of the result
  localparam int unsigned LG_GRP_W  = 4;   // width of one leaf detector
endpackage

// File: rtl/log2_lod_leaf.sv
// Priority detector: reports whether any bit is set and the index of the
// highest set bit as a binary number.
module log2_lod_leaf #(
  parameter int unsigned W  = 4,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  bits_i,
  output logic          hit_o,
  output logic [PW-1:0] idx_o
);
  always_comb begin
    hit_o = |bits_i;
    idx_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (bits_i[i]) idx_o = PW'(i);
    end
  end
endmodule

// File: rtl/log2_lod.sv
// Two-level leading-one detector: leaf detectors on fixed groups, then one
// detector across the group hit flags selecting the winning leaf index.
module log2_lod #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GRP_W  = 4,
  localparam int unsigned NGRP  = DATA_W / GRP_W,
  localparam int unsigned GPW   = $clog2(GRP_W),
  localparam int unsigned SPW   = $clog2(NGRP),
  localparam int unsigned POS_W = GPW + SPW
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              any_o,
  output logic [POS_W-1:0]  pos_o
);
  logic [NGRP-1:0] grp_hit;
  logic [GPW-1:0]  leaf_idx [NGRP];
  logic [SPW-1:0]  grp_idx;

  for (genvar g = 0; g < int'(NGRP); g++) begin : g_leaf
    log2_lod_leaf #(.W(GRP_W)) u_leaf (
      .bits_i (data_i[g*GRP_W +: GRP_W]),
      .hit_o  (grp_hit[g]),
      .idx_o  (leaf_idx[g])
    );
  end

  log2_lod_leaf #(.W(NGRP)) u_group (
    .bits_i (grp_hit),
    .hit_o  (any_o),
    .idx_o  (grp_idx)
  );

  assign pos_o = {grp_idx, leaf_idx[grp_idx]};
endmodule

// File: rtl/log2_norm_shift.sv
// Logarithmic left shifter: moves the leading one to the top bit position,
// one stage per bit of the shift amount, and returns the bits just below it.
module log2_norm_shift #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 12,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [FRAC_W-1:0] frac_o
);
  logic [POS_W-1:0]  amt;
  logic [DATA_W-1:0] stage [POS_W+1];

  assign amt      = POS_W'(DATA_W - 1) - pos_i;
  assign stage[0] = data_i;

  for (genvar k = 0; k < int'(POS_W); k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign frac_o = stage[POS_W][DATA_W-2 -: FRAC_W];

  if (FRAC_W < DATA_W - 1) begin : g_trunc
    logic unused_bits;
    assign unused_bits = ^{stage[POS_W][DATA_W-1], stage[POS_W][DATA_W-2-FRAC_W:0]};
  end else begin : g_full
    logic unused_bits;
    assign unused_bits = stage[POS_W][DATA_W-1];
  end
endmodule

// File: rtl/log2_conv.sv
// Binary logarithm converter: integer part from the leading-one position,
// fraction from the normalised bits below it, registered outputs.
module log2_conv
  import log2_pkg::*;
#(
  parameter int unsigned DATA_W = LG_DATA_W,
  parameter int unsigned FRAC_W = LG_FRAC_W,
  parameter int unsigned GRP_W  = LG_GRP_W,
  localparam int unsigned CHAR_W = $clog2(DATA_W),
  localparam int unsigned RES_W  = CHAR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_log,
  output logic              out_zero
);
  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // datapath
  logic              lod_any;
  logic [CHAR_W-1:0] lod_pos;
  logic [FRAC_W-1:0] sh_frac;

  log2_lod #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_lod (
    .data_i (in_data),
    .any_o  (lod_any),
    .pos_o  (lod_pos)
  );

  log2_norm_shift #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_shift (
    .data_i (in_data),
    .pos_i  (lod_pos),
    .frac_o (sh_frac)
  );

  // next state
  logic              cap_en;
  logic [CHAR_W-1:0] char_d, char_q;
  logic [FRAC_W-1:0] frac_d, frac_q;
  logic              zero_d, zero_q;
  logic              valid_q;

  always_comb begin
    cap_en = in_valid;
    zero_d = ~lod_any;
    char_d = lod_any ? lod_pos : '0;
    frac_d = lod_any ? sh_frac : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      char_q  <= '0;
      frac_q  <= '0;
      zero_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (cap_en) begin
        char_q <= char_d;
        frac_q <= frac_d;
        zero_q <= zero_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_log   = {char_q, frac_q};
  assign out_zero  = zero_q;
endmodule

// File: rtl/log2_conv_chk.sv
module log2_conv_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 12,
  localparam int unsigned CHAR_W = $clog2(DATA_W),
  localparam int unsigned RES_W  = CHAR_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [RES_W-1:0]  out_log,
  input logic              out_zero
);
  function automatic logic [FRAC_W-1:0] expect_frac(input logic [DATA_W-1:0] x,
                                                    input logic [CHAR_W-1:0] c);
    return FRAC_W'((x << (DATA_W - 1 - c)) >> (DATA_W - 1 - FRAC_W));
  endfunction

  // R1
  msb_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data != '0) |=>
      (($past(in_data) >> out_log[RES_W-1 -: CHAR_W]) == DATA_W'(1)));

  // R2
  frac_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data != '0) |=>
      (out_log[FRAC_W-1:0] == expect_frac($past(in_data), out_log[RES_W-1 -: CHAR_W])));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_zero == ($past(in_data) == '0)));

  // R4
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> (out_log == '0));

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_log) && $stable(out_zero)));
endmodule

bind log2_conv log2_conv_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_log   (out_log),
  .out_zero  (out_zero)
);

// File: tb/log2_conv_bench.sv
`timescale 1ns/1ps
module log2_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_log;
  logic        out_zero;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  log2_conv u_log2_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_log   (out_log),
    .out_zero  (out_zero)
  );

  // operand, expected result
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0001, 16'h0000},  // R1 R2 smallest nonzero
    {16'h0002, 16'h1000},  // R2 power of two
    {16'h0003, 16'h1800},  // R3
    {16'h0005, 16'h2400},  // R3
    {16'h00FF, 16'h7FE0},  // R3
    {16'h0100, 16'h8000},  // R1
    {16'h1000, 16'hC000},  // R1
    {16'h1FFF, 16'hCFFF},  // R2 exactly twelve bits below
    {16'h2345, 16'hD1A2},  // R2 truncation
    {16'h8001, 16'hF000},  // R2 low bit dropped
    {16'hA5A5, 16'hF4B4},  // R2
    {16'hFFFF, 16'hFFFF}   // R2 all ones
  };

  function automatic logic [15:0] model(input logic [15:0] x);
    int c;
    logic [11:0] f;
    if (x == 16'h0) return 16'h0;
    c = 0;
    for (int i = 0; i < 16; i++) if (x[i]) c = i;
    f = '0;
    for (int j = 0; j < 12; j++) begin
      if (c - 1 - j >= 0) f[11 - j] = x[c - 1 - j];
    end
    return {4'(c), f};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // caller stands at a falling edge; inputs change here, result is read at
  // the next falling edge (one rising edge in between)
  task automatic drive(input logic v, input logic [15:0] d);
    in_valid = v;
    in_data  = d;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    check("R7 reset log",   out_log, 16'h0);
    check("R7 reset zero",  {15'h0, out_zero}, 16'h0);
    check("R7 reset valid", {15'h0, out_valid}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][31:16]);
      check("R1/R2/R3 table", out_log, VEC[i][15:0]);
      check("R4 flag low", {15'h0, out_zero}, 16'h0);
      check("R5 valid", {15'h0, out_valid}, 16'h1);
    end

    // R4 zero operand
    drive(1'b1, 16'h0000);
    check("R4 zero log",  out_log, 16'h0);
    check("R4 zero flag", {15'h0, out_zero}, 16'h1);

    // R6 hold while idle, R5 valid drops
    drive(1'b1, 16'h00FF);
    drive(1'b0, 16'h0000);
    check("R6 hold log",  out_log, 16'h7FE0);
    check("R6 hold zero", {15'h0, out_zero}, 16'h0);
    check("R5 valid low", {15'h0, out_valid}, 16'h0);
    drive(1'b0, 16'h1234);
    check("R6 hold log 2", out_log, 16'h7FE0);
    drive(1'b1, 16'h0000);
    drive(1'b0, 16'hFFFF);
    check("R6 hold zero flag", {15'h0, out_zero}, 16'h1);
    check("R6 hold zero log",  out_log, 16'h0);

    // every operand
    for (int x = 0; x < 65536; x++) begin
      drive(1'b1, 16'(x));
      check("R1/R2/R3/R4 sweep", out_log, model(16'(x)));
    end

    // R7 asynchronous reset mid-run
    drive(1'b1, 16'hFFFF);
    check("R7 before reset", out_log, 16'hFFFF);
    #1 rst_n = 1'b0;
    #0.5;
    check("R7 async log",   out_log, 16'h0);
    check("R7 async valid", {15'h0, out_valid}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 16'h0005);
    check("R7 after reset", out_log, 16'h2400);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule